// File: doc/BRIEF.md
# Paired-Compare PWM with Fractional Edge Dithering

This block produces one pulse-width-modulated output from a timer that counts upward from a programmable start value to a programmable top value. When the counter reaches the top value, it reloads the start value, and that reload marks the end of the PWM period. The pin becomes active when the counter reaches the set-compare value. It becomes inactive again when the counter reaches the clear-compare value. A polarity input can invert the pin. A one-cycle strobe marks the last count of every period.

Finer average resolution comes from a 5-bit fractional value per compare. At each period boundary, that value is added into a 5-bit accumulator. When the sum carries past 31, the accumulator keeps the remainder. In the following period, the matching edge moves one count later. Over 32 periods, the edge therefore slips by a number of counts equal to the fractional value. A fractional value of zero leaves the edge fixed. The clear edge has its own accumulator and fractional input, which the `DITHER_B` parameter includes. When the effective set edge reaches or passes the effective clear edge, the period carries no pulse. While the enable is low, the counter stays at the start value, both accumulators are emptied and the pin rests inactive.

Top module: `dpwm_pair`

## Requirements
- R1: While reset is asserted, `period_stb` is 0 and `pwm_out` equals `pol`.
- R2: With `en` high, the counter steps by one from `cnt_init` to `cnt_mod`. It then reloads `cnt_init`, so one period lasts `cnt_mod - cnt_init + 1` cycles, and `period_stb` is high for exactly one cycle per period.
- R3: With both fractional values zero, the pin is active for counter values c where `match_a <= c < match_b`, in every period.
- R4: Each accumulator is 5 bits wide and starts at 0. At each period end, its fractional value is added to it. A sum of 32 or more is an overflow, and the accumulator then keeps the sum minus 32.
- R5: In the period after an overflow of the set-edge accumulator, the set edge occurs at `match_a + 1` instead of `match_a`.
- R6: With `DITHER_B = 1` (the default), the period after an overflow of the clear-edge accumulator, fed by `frac_b`, moves the clear edge to `match_b + 1`.
- R7: When the effective set edge is greater than or equal to the effective clear edge, the pin stays inactive for the whole period.
- R8: `pwm_out` is the internal active level XOR `pol`, so `pol = 1` gives an active-low pin.
- R9: While `en` is low, the counter holds `cnt_init`, `period_stb` stays 0 and the pin stays inactive. Both accumulators are cleared, so the first period after re-enabling is undithered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds and clears the timer |
| cnt_init | input | CNT_W | Counter start value |
| cnt_mod | input | CNT_W | Counter top value, last count of a period |
| match_a | input | CNT_W | Set-edge compare value |
| match_b | input | CNT_W | Clear-edge compare value |
| frac_a | input | 5 | Fractional dither value for the set edge |
| frac_b | input | 5 | Fractional dither value for the clear edge |
| pol | input | 1 | Pin polarity, 1 inverts |
| pwm_out | output | 1 | PWM pin |
| period_stb | output | 1 | High during the last count of each period |

## Verification
The bench measures the active width and the length of every period and compares them with a model of the accumulators. The model catches an accumulator that keeps its carry, drops the remainder or updates in the wrong period, because each of those faults shifts the one-count wide/narrow pattern. Separate cases cover compare values outside the count range, a set edge equal to the clear edge, and a set edge that reaches the clear edge only when dithered. A design that compares against the undithered edge would emit a spurious one-count pulse in those cases. Another case disables the block right after a carrying period and then re-enables it. A design that fails to clear its accumulators would start the new run with a narrowed first pulse.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int FRAC_W   = 5;
  localparam int FRAC_SUM = FRAC_W + 1;
  typedef logic [FRAC_W-1:0] frac_t;
endpackage

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt_init,
  input  logic [CNT_W-1:0] cnt_mod,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             period_stb
);
  logic [CNT_W-1:0] cnt_d;
  logic             stb_d;

  always_comb begin
    wrap  = en && (cnt_q == cnt_mod);
    stb_d = wrap;
    if (!en || wrap) begin
      cnt_d = cnt_init;
    end else begin
      cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      period_stb <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      period_stb <= stb_d;
    end
  end
endmodule

// File: rtl/dpwm_frac_acc.sv
module dpwm_frac_acc
  import dpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  wrap,
  input  frac_t frac,
  output frac_t acc_q,
  output logic  ovf_q
);
  logic [FRAC_SUM-1:0] sum;
  frac_t               acc_d;
  logic                ovf_d;
  logic                upd;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, frac};
    upd   = !en || wrap;
    acc_d = acc_q;
    ovf_d = ovf_q;
    if (!en) begin
      acc_d = '0;
      ovf_d = 1'b0;
    end else if (wrap) begin
      acc_d = sum[FRAC_W-1:0];
      ovf_d = sum[FRAC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd) begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/dpwm_edge_gen.sv
module dpwm_edge_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] match_a,
  input  logic [CNT_W-1:0] match_b,
  input  logic             ovf_a,
  input  logic             ovf_b,
  input  logic             pol,
  output logic             pwm_out
);
  localparam int EW = CNT_W + 1;

  logic [EW-1:0] edge_a;
  logic [EW-1:0] edge_b;
  logic [EW-1:0] cnt_x;
  logic          active_d;
  logic          active_q;

  always_comb begin
    edge_a   = {1'b0, match_a} + {{CNT_W{1'b0}}, ovf_a};
    edge_b   = {1'b0, match_b} + {{CNT_W{1'b0}}, ovf_b};
    cnt_x    = {1'b0, cnt_q};
    active_d = en && (cnt_x >= edge_a) && (cnt_x < edge_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
    end
  end

  assign pwm_out = active_q ^ pol;
endmodule

// File: rtl/dpwm_pair.sv
module dpwm_pair
  import dpwm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit DITHER_B = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CNT_W-1:0]  cnt_init,
  input  logic [CNT_W-1:0]  cnt_mod,
  input  logic [CNT_W-1:0]  match_a,
  input  logic [CNT_W-1:0]  match_b,
  input  logic [FRAC_W-1:0] frac_a,
  input  logic [FRAC_W-1:0] frac_b,
  input  logic              pol,
  output logic              pwm_out,
  output logic              period_stb
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;
  frac_t            acc_a;
  frac_t            acc_b;
  logic             ovf_a;
  logic             ovf_b;

  dpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cnt_init   (cnt_init),
    .cnt_mod    (cnt_mod),
    .cnt_q      (cnt_q),
    .wrap       (wrap),
    .period_stb (period_stb)
  );

  dpwm_frac_acc u_acc_a (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .wrap  (wrap),
    .frac  (frac_a),
    .acc_q (acc_a),
    .ovf_q (ovf_a)
  );

  generate
    if (DITHER_B) begin : g_dither_b
      dpwm_frac_acc u_acc_b (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .wrap  (wrap),
        .frac  (frac_b),
        .acc_q (acc_b),
        .ovf_q (ovf_b)
      );
    end else begin : g_fixed_b
      assign acc_b = '0;
      assign ovf_b = 1'b0;
    end
  endgenerate

  dpwm_edge_gen #(.CNT_W(CNT_W)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .cnt_q   (cnt_q),
    .match_a (match_a),
    .match_b (match_b),
    .ovf_a   (ovf_a),
    .ovf_b   (ovf_b),
    .pol     (pol),
    .pwm_out (pwm_out)
  );
endmodule

// File: rtl/dpwm_pair_chk.sv
module dpwm_pair_chk
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CNT_W-1:0] cnt_init,
  input logic [CNT_W-1:0] cnt_mod,
  input logic [CNT_W-1:0] match_a,
  input logic [CNT_W-1:0] match_b,
  input frac_t            frac_a,
  input logic             pol,
  input logic [CNT_W-1:0] cnt_q,
  input frac_t            acc_a,
  input frac_t            acc_b,
  input logic             ovf_a,
  input logic             ovf_b,
  input logic             pwm_out,
  input logic             period_stb
);
  logic [CNT_W:0]  ea_chk;
  logic [CNT_W:0]  eb_chk;
  logic [FRAC_W:0] suma_chk;

  always_comb begin
    ea_chk   = {1'b0, match_a} + {{CNT_W{1'b0}}, ovf_a};
    eb_chk   = {1'b0, match_b} + {{CNT_W{1'b0}}, ovf_b};
    suma_chk = {1'b0, acc_a} + {1'b0, frac_a};
  end

  // R2
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q != cnt_mod) |=> (!en || cnt_q == $past(cnt_q) + 1'b1));

  // R2
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == cnt_mod) |=> (period_stb && cnt_q == $past(cnt_init)));

  // R4
  p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q != cnt_mod) |=> (!en || $stable(acc_a)));

  // R5
  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == cnt_mod && suma_chk >= 6'd32) |=> ovf_a);

  // R6
  p_acc_b_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q != cnt_mod) |=> (!en || $stable(acc_b)));

  // R7
  p_nopulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ea_chk >= eb_chk) |=> (!$stable(pol) || pwm_out == pol));

  // R9
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (!period_stb && acc_a == '0 && !ovf_a));
endmodule

bind dpwm_pair dpwm_pair_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dpwm_pair_bench.sv
module dpwm_pair_bench;
  localparam int W = 16;

  typedef struct packed {
    logic [W-1:0] init;
    logic [W-1:0] top;
    logic [W-1:0] ma;
    logic [W-1:0] mb;
    logic [4:0]   fa;
    logic [4:0]   fb;
    logic         pol;
    logic [7:0]   np;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'd0, 16'd9,  16'd2, 16'd7,  5'd0,  5'd0,  1'b0, 8'd4},
    '{16'd3, 16'd12, 16'd5, 16'd10, 5'd3,  5'd0,  1'b0, 8'd12},
    '{16'd0, 16'd15, 16'd4, 16'd12, 5'd31, 5'd0,  1'b1, 8'd6},
    '{16'd0, 16'd7,  16'd3, 16'd6,  5'd0,  5'd17, 1'b0, 8'd6},
    '{16'd0, 16'd7,  16'd5, 16'd5,  5'd0,  5'd0,  1'b0, 8'd3},
    '{16'd0, 16'd7,  16'd5, 16'd6,  5'd16, 5'd0,  1'b0, 8'd4},
    '{16'd2, 16'd10, 16'd0, 16'd20, 5'd8,  5'd0,  1'b0, 8'd5},
    '{16'd0, 16'd5,  16'd0, 16'd3,  5'd1,  5'd1,  1'b0, 8'd3}
  };

  logic         clk;
  logic         rst_n;
  logic         en;
  logic [W-1:0] cnt_init;
  logic [W-1:0] cnt_mod;
  logic [W-1:0] match_a;
  logic [W-1:0] match_b;
  logic [4:0]   frac_a;
  logic [4:0]   frac_b;
  logic         pol;
  logic         pwm_out;
  logic         period_stb;

  int n_chk;
  int n_bad;
  bit done;

  dpwm_pair #(.CNT_W(W), .DITHER_B(1'b1)) u_dpwm_pair (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt_init(cnt_init), .cnt_mod(cnt_mod),
    .match_a(match_a), .match_b(match_b), .frac_a(frac_a), .frac_b(frac_b),
    .pol(pol), .pwm_out(pwm_out), .period_stb(period_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_width(input int init, input int top, input int ea, input int eb);
    int w = 0;
    for (int c = init; c <= top; c++) begin
      if (c >= ea && c < eb) w++;
    end
    return w;
  endfunction

  function automatic string tag_of(input vec_t v);
    if (v.ma >= v.mb) return "R7";
    if (v.fb != 0)    return "R6";
    if (v.fa != 0)    return "R4 R5";
    if (v.pol)        return "R8";
    return "R3";
  endfunction

  task automatic run_vec(input vec_t v, input string tag);
    int acc_a = 0, acc_b = 0, oa = 0, ob = 0, s = 0;
    int w, len, guard;
    @(negedge clk);
    en       = 1'b0;
    cnt_init = v.init;
    cnt_mod  = v.top;
    match_a  = v.ma;
    match_b  = v.mb;
    frac_a   = v.fa;
    frac_b   = v.fb;
    pol      = v.pol;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9", "idle pin", int'(pwm_out), int'(v.pol));
      check("R9", "idle strobe", int'(period_stb), 0);
    end
    en = 1'b1;
    for (int p = 0; p < int'(v.np); p++) begin
      w = 0; len = 0; guard = 0;
      do begin
        @(negedge clk);
        len++;
        guard++;
        if (pwm_out ^ v.pol) w++;
      end while (!period_stb && guard < 70000);
      check(tag, "active width",
            w, exp_width(int'(v.init), int'(v.top), int'(v.ma) + oa, int'(v.mb) + ob));
      check("R2", "period length", len, int'(v.top) - int'(v.init) + 1);
      s = acc_a + int'(v.fa); oa = (s >= 32) ? 1 : 0; acc_a = s % 32;
      s = acc_b + int'(v.fb); ob = (s >= 32) ? 1 : 0; acc_b = s % 32;
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; en = 1'b0;
    cnt_init = '0; cnt_mod = 16'd7; match_a = '0; match_b = '0;
    frac_a = '0; frac_b = '0; pol = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset pin pol0", int'(pwm_out), 0);
    check("R1", "reset strobe", int'(period_stb), 0);
    pol = 1'b1;
    @(negedge clk);
    check("R1", "reset pin pol1", int'(pwm_out), 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], tag_of(VECS[i]));
    end

    // R9: carry pending at disable, then re-enable must start undithered
    run_vec('{16'd0, 16'd7, 16'd2, 16'd6, 5'd31, 5'd0, 1'b0, 8'd3}, "R5");
    run_vec('{16'd0, 16'd7, 16'd2, 16'd6, 5'd31, 5'd0, 1'b0, 8'd1}, "R9");

    // R7: set edge above clear edge, inverted pin stays high
    run_vec('{16'd0, 16'd9, 16'd8, 16'd3, 5'd5, 5'd0, 1'b1, 8'd2}, "R7");

    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule